// File: doc/BRIEF.md
# GPIO Bank with Four-Way Peripheral Multiplexer

This block controls a bank of 32 I/O pads. Each pad is owned either by the general-purpose I/O logic or by one of four on-chip peripheral functions, A to D. When the I/O logic owns a pad, it drives the pad's output level and output enable from its own registers. When a peripheral owns the pad, the level and enable come from that peripheral's output and enable vectors. Every pad also carries pull-up, pull-down, Schmitt-trigger-disable, input-filter-enable, interrupt-enable and open-drain settings. The pad control signals and the enables for the filter and interrupt logic leave the block as plain vectors.

Software reaches the block through a plain synchronous port with a 5-bit word address and a 32-bit data bus. Bit n of every register belongs to pad n. Each on/off attribute has three addresses: a set strobe, a clear strobe and a status word. Writing a 1 in a strobe word changes that pad's attribute, and writing a 0 leaves it unchanged. Software can therefore change one pad without first reading the register. The two function-select words, the Schmitt-disable word and a live pad-level word make up the rest of the map.

Top module: `gpio_bank_mux`

## Requirements
- R1: After reset, every pad is owned by the I/O logic with its output disabled. Output data is 0, pull-ups are on, pull-downs are off, open-drain is off, interrupt and filter enables are off, and the select and Schmitt-disable words are 0.
- R2: There are eight attributes, indexed k = 0..7: ownership, output enable, output data, pull-up, pull-down, interrupt enable, filter enable and open-drain. Writing to address 3k sets the attribute on every pad whose data bit is 1. Writing to 3k+1 clears it on those pads. Pads whose bit is 0 keep their value. The change is visible from the clock edge that takes the write.
- R3: A read of address 3k+2 returns the status of attribute k. A 1 in the ownership status means the I/O logic owns the pad, and a 0 means a peripheral owns it.
- R4: When the I/O logic owns a pad and open-drain is off, pad_out follows the output-data bit and pad_oe follows the output-enable bit.
- R5: When a peripheral owns a pad, the select bits at address 24 (s1) and address 25 (s2) choose the source. (s1,s2) = (0,0) selects function A, (1,0) selects B, (0,1) selects C and (1,1) selects D. pad_out and pad_oe then come from that function's output and enable bits. Both select words are read/write.
- R6: With open-drain on, a pad never drives high. pad_out is 0, and pad_oe equals the source enable AND the inverse of the source level. This holds whichever source owns the pad.
- R7: Pull-up and pull-down are never on together. Setting the pull-down on a pad clears its pull-up, and setting the pull-up clears its pull-down.
- R8: The Schmitt-disable word at address 26 is read/write, and a 1 drives pad_st_dis high for that pad.
- R9: A read of address 27 returns the sampled pad_in level of every pad, whatever owns the pad.
- R10: Read data appears on rdata in the cycle after rd_en is taken and holds until the next read. Addresses 28 to 31 and the set/clear addresses read as 0.
- R11: irq_en, flt_en, pad_pu and pad_pd reflect the interrupt-enable, filter-enable, pull-up and pull-down attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data, one bit per pad |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| pad_in | input | 32 | Sampled pad levels |
| per_a_out | input | 32 | Function A output levels |
| per_b_out | input | 32 | Function B output levels |
| per_c_out | input | 32 | Function C output levels |
| per_d_out | input | 32 | Function D output levels |
| per_a_oe | input | 32 | Function A output enables |
| per_b_oe | input | 32 | Function B output enables |
| per_c_oe | input | 32 | Function C output enables |
| per_d_oe | input | 32 | Function D output enables |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output enable |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |
| pad_st_dis | output | 32 | Schmitt trigger disable |
| irq_en | output | 32 | Interrupt enable per pad |
| flt_en | output | 32 | Input filter enable per pad |

## Verification
The register assertions assume that wr_en addresses one word per cycle. Under that assumption, a pad never sees a set and a clear strobe for the same attribute in the same cycle. The only exception is the pull interlock, where a pull-down set acts as a pull-up clear. The bench issues one write at a time and sets the strobes only between clock edges. The open-drain and pull-exclusion properties make no assumption about the peripheral vectors, so the bench drives those vectors and pad_in with arbitrary values that change on every step.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int GPB_AW = 5;

    // attribute indices; each has set at 3k, clear at 3k+1, status at 3k+2
    localparam int ATR_OWN = 0;
    localparam int ATR_OE  = 1;
    localparam int ATR_DAT = 2;
    localparam int ATR_PU  = 3;
    localparam int ATR_PD  = 4;
    localparam int ATR_IE  = 5;
    localparam int ATR_FLT = 6;
    localparam int ATR_MD  = 7;
    localparam int NATTR   = 8;

    localparam logic [GPB_AW-1:0] AD_SEL1  = GPB_AW'(3 * NATTR);
    localparam logic [GPB_AW-1:0] AD_SEL2  = GPB_AW'(3 * NATTR + 1);
    localparam logic [GPB_AW-1:0] AD_STDIS = GPB_AW'(3 * NATTR + 2);
    localparam logic [GPB_AW-1:0] AD_LEVEL = GPB_AW'(3 * NATTR + 3);

    typedef enum logic [1:0] {
        FN_A = 2'd0,
        FN_B = 2'd1,
        FN_C = 2'd2,
        FN_D = 2'd3
    } gpb_fn_e;

    typedef struct packed {
        logic lvl;
        logic en;
    } gpb_drv_t;

    function automatic logic [GPB_AW-1:0] attr_addr(input int attr, input int slot);
        return GPB_AW'(3 * attr + slot);
    endfunction

    function automatic gpb_fn_e fn_of(input logic s1, input logic s2);
        return gpb_fn_e'({s2, s1});
    endfunction

endpackage

// File: rtl/gpb_attr_reg.sv
module gpb_attr_reg #(
    parameter int           W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) q_r <= RST;
        else     q_r <= (q_r & ~clr_v) | set_v;
    end

    assign q = q_r;

    // R2: strobed bits take the new value, the others keep theirs
    a_r2_set: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((q & $past(set_v)) == $past(set_v)));
    a_r2_clear: assert property (@(posedge clk) disable iff (rst)
        ((|clr_v) && (set_v == '0)) |=> ((q & $past(clr_v)) == '0));
    a_r2_keep: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((q ^ $past(q)) & ~$past(set_v | clr_v)) == '0));

endmodule

// File: rtl/gpb_rw_reg.sv
module gpb_rw_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end

    // R8: a plain word holds the last written data
    a_r8_write: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(d)));

endmodule

// File: rtl/gpb_pad_mux.sv
module gpb_pad_mux
    import gpb_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] own,
    input  logic [NPINS-1:0] dat,
    input  logic [NPINS-1:0] oe,
    input  logic [NPINS-1:0] md,
    input  logic [NPINS-1:0] sel1,
    input  logic [NPINS-1:0] sel2,
    input  logic [NPINS-1:0] pa_o,
    input  logic [NPINS-1:0] pb_o,
    input  logic [NPINS-1:0] pc_o,
    input  logic [NPINS-1:0] pd_o,
    input  logic [NPINS-1:0] pa_e,
    input  logic [NPINS-1:0] pb_e,
    input  logic [NPINS-1:0] pc_e,
    input  logic [NPINS-1:0] pd_e,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpb_drv_t src;
        gpb_drv_t drv;

        always_comb begin
            unique case (fn_of(sel1[i], sel2[i]))
                FN_A:    src = '{lvl: pa_o[i], en: pa_e[i]};
                FN_B:    src = '{lvl: pb_o[i], en: pb_e[i]};
                FN_C:    src = '{lvl: pc_o[i], en: pc_e[i]};
                default: src = '{lvl: pd_o[i], en: pd_e[i]};
            endcase
            if (own[i]) src = '{lvl: dat[i], en: oe[i]};
            drv.lvl = src.lvl & ~md[i];
            drv.en  = src.en & ~(md[i] & src.lvl);
        end

        assign pad_out[i] = drv.lvl;
        assign pad_oe[i]  = drv.en;

        // R6: an open-drain pad never drives a high level
        a_r6_no_high: assert property (@(posedge clk) disable iff (rst)
            md[i] |-> !pad_out[i]);
    end

endmodule

// File: rtl/gpio_bank_mux.sv
module gpio_bank_mux
    import gpb_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [GPB_AW-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pad_in,
    input  logic [NPINS-1:0]  per_a_out,
    input  logic [NPINS-1:0]  per_b_out,
    input  logic [NPINS-1:0]  per_c_out,
    input  logic [NPINS-1:0]  per_d_out,
    input  logic [NPINS-1:0]  per_a_oe,
    input  logic [NPINS-1:0]  per_b_oe,
    input  logic [NPINS-1:0]  per_c_oe,
    input  logic [NPINS-1:0]  per_d_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd,
    output logic [NPINS-1:0]  pad_st_dis,
    output logic [NPINS-1:0]  irq_en,
    output logic [NPINS-1:0]  flt_en
);

    localparam logic [NPINS-1:0] ALL1 = {NPINS{1'b1}};

    logic [NPINS-1:0] set_raw [NATTR];
    logic [NPINS-1:0] clr_raw [NATTR];
    logic [NPINS-1:0] clr_eff [NATTR];
    logic [NPINS-1:0] att_q   [NATTR];
    logic [NPINS-1:0] sel1_q, sel2_q, stdis_q;
    logic [NPINS-1:0] rd_mux;
    logic [NPINS-1:0] rdata_q;

    // strobe decode
    always_comb begin
        for (int a = 0; a < NATTR; a++) begin
            set_raw[a] = (wr_en && addr == attr_addr(a, 0)) ? wdata : '0;
            clr_raw[a] = (wr_en && addr == attr_addr(a, 1)) ? wdata : '0;
        end
    end

    // pull interlock: setting one pull clears the other
    always_comb begin
        for (int a = 0; a < NATTR; a++) clr_eff[a] = clr_raw[a];
        clr_eff[ATR_PU] = clr_raw[ATR_PU] | set_raw[ATR_PD];
        clr_eff[ATR_PD] = clr_raw[ATR_PD] | set_raw[ATR_PU];
    end

    for (genvar g = 0; g < NATTR; g++) begin : g_attr
        localparam logic [NPINS-1:0] RV = (g == ATR_OWN || g == ATR_PU) ? ALL1 : '0;
        gpb_attr_reg #(.W(NPINS), .RST(RV)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .set_v (set_raw[g]),
            .clr_v (clr_eff[g]),
            .q     (att_q[g])
        );
    end

    gpb_rw_reg #(.W(NPINS)) u_sel1 (
        .clk (clk), .rst (rst), .we (wr_en && addr == AD_SEL1), .d (wdata), .q (sel1_q));
    gpb_rw_reg #(.W(NPINS)) u_sel2 (
        .clk (clk), .rst (rst), .we (wr_en && addr == AD_SEL2), .d (wdata), .q (sel2_q));
    gpb_rw_reg #(.W(NPINS)) u_stdis (
        .clk (clk), .rst (rst), .we (wr_en && addr == AD_STDIS), .d (wdata), .q (stdis_q));

    // read selection
    always_comb begin
        rd_mux = '0;
        for (int a = 0; a < NATTR; a++) begin
            if (addr == attr_addr(a, 2)) rd_mux = att_q[a];
        end
        if (addr == AD_SEL1)  rd_mux = sel1_q;
        if (addr == AD_SEL2)  rd_mux = sel2_q;
        if (addr == AD_STDIS) rd_mux = stdis_q;
        if (addr == AD_LEVEL) rd_mux = pad_in;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;

    gpb_pad_mux #(.NPINS(NPINS)) u_mux (
        .clk     (clk),
        .rst     (rst),
        .own     (att_q[ATR_OWN]),
        .dat     (att_q[ATR_DAT]),
        .oe      (att_q[ATR_OE]),
        .md      (att_q[ATR_MD]),
        .sel1    (sel1_q),
        .sel2    (sel2_q),
        .pa_o    (per_a_out),
        .pb_o    (per_b_out),
        .pc_o    (per_c_out),
        .pd_o    (per_d_out),
        .pa_e    (per_a_oe),
        .pb_e    (per_b_oe),
        .pc_e    (per_c_oe),
        .pd_e    (per_d_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign pad_pu     = att_q[ATR_PU];
    assign pad_pd     = att_q[ATR_PD];
    assign pad_st_dis = stdis_q;
    assign irq_en     = att_q[ATR_IE];
    assign flt_en     = att_q[ATR_FLT];

    // R7: the two pulls are never on together
    a_r7_pull_excl: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_pd) == '0);

    // R10: read data holds between reads
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/test_gpio_bank_mux.sv
module test_gpio_bank_mux;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pao = '0, pbo = '0, pco = '0, pdo = '0;
    logic [NP-1:0] pae = '0, pbe = '0, pce = '0, pde = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_st_dis, irq_en, flt_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // shadow model: attributes 0..7, selects, Schmitt disable
    logic [NP-1:0] m_att [8];
    logic [NP-1:0] m_s1, m_s2, m_st;

    always #5 clk = ~clk;

    gpio_bank_mux #(.NPINS(NP)) i_gpio_bank_mux (
        .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
        .wdata (wdata), .rdata (rdata), .pad_in (pad_in),
        .per_a_out (pao), .per_b_out (pbo), .per_c_out (pco), .per_d_out (pdo),
        .per_a_oe (pae), .per_b_oe (pbe), .per_c_oe (pce), .per_d_oe (pde),
        .pad_out (pad_out), .pad_oe (pad_oe), .pad_pu (pad_pu), .pad_pd (pad_pd),
        .pad_st_dis (pad_st_dis), .irq_en (irq_en), .flt_en (flt_en)
    );

    task automatic chk(input string req, input string what, input logic [NP-1:0] got,
                       input logic [NP-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [NP-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 24 && a % 3 == 0) begin
            m_att[a/3] = m_att[a/3] | d;
            if (a/3 == 3) m_att[4] = m_att[4] & ~d;
            if (a/3 == 4) m_att[3] = m_att[3] & ~d;
        end else if (a < 24 && a % 3 == 1) begin
            m_att[a/3] = m_att[a/3] & ~d;
        end else if (a == 24) m_s1 = d;
        else if (a == 25) m_s2 = d;
        else if (a == 26) m_st = d;
    endtask

    task automatic rd(input int a, output logic [NP-1:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = 5'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic check_pads(input string tag);
        logic [NP-1:0] fa, fb, fc, fd, so, se, own, md;
        fa = ~m_s1 & ~m_s2; fb = m_s1 & ~m_s2; fc = ~m_s1 & m_s2; fd = m_s1 & m_s2;
        own = m_att[0]; md = m_att[7];
        so = (own & m_att[2]) | (~own & ((fa & pao) | (fb & pbo) | (fc & pco) | (fd & pdo)));
        se = (own & m_att[1]) | (~own & ((fa & pae) | (fb & pbe) | (fc & pce) | (fd & pde)));
        chk("R4/R5/R6", {tag, " pad_out"}, pad_out, so & ~md);
        chk("R4/R5/R6", {tag, " pad_oe"}, pad_oe, se & ~(md & so));
        chk("R11", {tag, " pad_pu"}, pad_pu, m_att[3]);
        chk("R11", {tag, " pad_pd"}, pad_pd, m_att[4]);
        chk("R7", {tag, " pull overlap"}, pad_pu & pad_pd, '0);
        chk("R11", {tag, " irq_en"}, irq_en, m_att[5]);
        chk("R11", {tag, " flt_en"}, flt_en, m_att[6]);
        chk("R8", {tag, " pad_st_dis"}, pad_st_dis, m_st);
    endtask

    task automatic check_status(input string tag);
        logic [NP-1:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(3*k + 2, v);
            chk("R3", $sformatf("%s status attr %0d", tag, k), v, m_att[k]);
        end
        rd(24, v); chk("R5", {tag, " sel1 readback"}, v, m_s1);
        rd(25, v); chk("R5", {tag, " sel2 readback"}, v, m_s2);
        rd(26, v); chk("R8", {tag, " stdis readback"}, v, m_st);
    endtask

    task automatic shuffle_inputs();
        @(negedge clk);
        pao = $urandom; pbo = $urandom; pco = $urandom; pdo = $urandom;
        pae = $urandom; pbe = $urandom; pce = $urandom; pde = $urandom;
        pad_in = $urandom;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] v, hold;
        m_att[0] = '1; m_att[3] = '1;
        m_att[1] = '0; m_att[2] = '0; m_att[4] = '0;
        m_att[5] = '0; m_att[6] = '0; m_att[7] = '0;
        m_s1 = '0; m_s2 = '0; m_st = '0;
        void'($urandom(32'h1234_5678));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "reset rdata", rdata, '0);
        chk("R1", "reset pad_oe", pad_oe, '0);
        chk("R1", "reset pad_out", pad_out, '0);
        chk("R1", "reset pad_pu", pad_pu, '1);
        chk("R1", "reset pad_pd", pad_pd, '0);
        check_pads("R1 reset");
        check_status("R1 reset");

        // R2: a zero-data strobe changes nothing
        wr(0 + 1, '0);
        rd(2, v); chk("R2", "zero clear keeps ownership", v, '1);

        // R4: I/O-owned push-pull drive
        wr(3, 32'hFFFF_FFFF);
        wr(6, 32'hA5C3_0F96);
        chk("R4", "pad_out follows data", pad_out, 32'hA5C3_0F96);
        chk("R4", "pad_oe follows enable", pad_oe, '1);
        wr(7, 32'h0000_0F00);
        chk("R2", "clear only strobed data bits", pad_out, 32'hA5C3_0096);

        // R6: open-drain on I/O-owned pads
        wr(21, 32'hFFFF_FFFF);
        chk("R6", "open-drain no high level", pad_out, '0);
        chk("R6", "open-drain enable when low", pad_oe, ~32'hA5C3_0096);
        wr(22, 32'hFFFF_FFFF);

        // R5: each function code for all pads
        wr(1, 32'hFFFF_FFFF);
        for (int f = 0; f < 4; f++) begin
            shuffle_inputs();
            wr(24, f[0] ? '1 : '0);
            wr(25, f[1] ? '1 : '0);
            case (f)
                0: begin chk("R5", "code A out", pad_out, pao); chk("R5", "code A oe", pad_oe, pae); end
                1: begin chk("R5", "code B out", pad_out, pbo); chk("R5", "code B oe", pad_oe, pbe); end
                2: begin chk("R5", "code C out", pad_out, pco); chk("R5", "code C oe", pad_oe, pce); end
                default: begin chk("R5", "code D out", pad_out, pdo); chk("R5", "code D oe", pad_oe, pde); end
            endcase
        end
        // mixed codes across pads
        wr(24, 32'h5555_5555);
        wr(25, 32'h3333_3333);
        check_pads("R5 mixed");
        // R6 on peripheral-owned pads
        wr(21, 32'h0F0F_F0F0);
        check_pads("R6 peripheral open-drain");

        // R7: pull interlock
        wr(12, 32'h0000_FFFF);
        chk("R7", "pull-down set clears pull-up", pad_pu, 32'hFFFF_0000);
        wr(9, 32'h00FF_00FF);
        chk("R7", "pull-up set clears pull-down", pad_pd, 32'h0000_FF00);
        check_pads("R7");

        // R8 / R11
        wr(26, 32'hDEAD_BEEF);
        wr(15, 32'h1357_9BDF);
        wr(18, 32'h2468_ACE0);
        check_pads("R8 R11");

        // R9: level readback whatever the owner
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); pad_in = $urandom;
            hold = pad_in;
            rd(27, v); chk("R9", "pad level readback", v, hold);
        end

        // R10: unmapped and strobe addresses read 0, and data holds
        for (int a = 28; a < 32; a++) begin
            rd(a, v); chk("R10", $sformatf("unmapped %0d", a), v, '0);
        end
        rd(0, v); chk("R10", "set address reads 0", v, '0);
        rd(26, hold);
        wr(26, 32'h0BAD_F00D);
        repeat (2) @(negedge clk);
        chk("R10", "rdata holds without read", rdata, hold);

        // near-exhaustive sweep of writable addresses with random data
        for (int it = 0; it < 60; it++) begin
            int a;
            shuffle_inputs();
            a = it % 27;
            if (a < 24 && a % 3 == 2) a = a - 2;
            wr(a, $urandom);
            check_pads($sformatf("R2 sweep %0d", it));
            if (it % 6 == 5) check_status($sformatf("R3 sweep %0d", it));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule